// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This unit keeps the 64-bit compare value that sets when the next supervisor timer interrupt is due. It drives the supervisor timer pending bit from a registered comparison against a free-running 64-bit time input. Because of this, the pending bit rises by itself once time reaches the compare value, and software does not have to rewrite anything. Software reaches the compare value through two CSR addresses. The low address is 0x14D. The high address is 0x15D and is used only when the core runs with 32-bit registers. The addresses are decoded combinationally, so read data and the illegal-access flag are valid in the same cycle as the request, and a legal write takes effect at the next clock edge.

Every access is checked against the current privilege level, a feature-enable input, a time-source-present input, the time bit of the machine counter-enable register and the timer-compare enable bit of the machine environment-config register. The unit also filters the write mask that the CSR file uses for the interrupt-pending register. While the feature is active in machine mode, software cannot write the supervisor and virtual-supervisor timer pending bits.

The pending bit comes from a two-state machine. PEND_ARMED means the compare value is later than the time input. PEND_DUE means the compare value is at or below the time input. The transition ARMED->DUE is taken when the comparison becomes true and DUE->ARMED when it becomes false. Both states hold otherwise. Reset enters PEND_ARMED.

Top module: `suptmr_cmp_unit`

## Requirements
- R1: Reset clears the compare value to zero and holds the pending output low. After reset is released, a zero compare value counts as due.
- R2: A legal write to address 0x14D replaces only bits 31:0 and keeps bits 63:32 when rv64_mode is 0. When rv64_mode is 1 it replaces all 64 bits.
- R3: A legal write to address 0x15D replaces bits 63:32 with wdata[31:0] and keeps bits 31:0. A read of 0x15D returns bits 63:32, zero-extended.
- R4: tmr_pend_o is high exactly when the compare value is less than or equal to time_now (unsigned), one clock after the values that decide it. It follows time_now without a new write.
- R5: Any access raises csr_illegal and has no effect when feat_en is 0 or time_ok is 0.
- R6: In machine mode (priv_lvl 3), an access to 0x14D is legal whenever feat_en and time_ok are 1, whatever the two enable bits are.
- R7: In supervisor mode (priv_lvl 1), an access is legal only when both cnt_time_en and env_tcmp_en are 1. Otherwise csr_illegal is raised and a write is ignored.
- R8: In user mode (priv_lvl 0), and with the unused encoding 2, every access raises csr_illegal and a write is ignored.
- R9: An access to 0x15D while rv64_mode is 1 raises csr_illegal and a write is ignored.
- R10: When feat_en is 1, priv_lvl is 3 and env_tcmp_en is 1, ip_wmask_o equals ip_wmask_i with bits 5 (supervisor timer) and 6 (virtual-supervisor timer) cleared. Otherwise ip_wmask_o equals ip_wmask_i.
- R11: A legal read of 0x14D returns the full 64-bit value when rv64_mode is 1, and bits 31:0 zero-extended when rv64_mode is 0. An illegal access or a non-matching address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Timer-compare feature enabled |
| time_ok | input | 1 | A time source is present |
| rv64_mode | input | 1 | 1: 64-bit registers, 0: 32-bit registers |
| priv_lvl | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cnt_time_en | input | 1 | Time bit of the machine counter-enable register |
| env_tcmp_en | input | 1 | Timer-compare enable bit of the machine environment-config register |
| csr_req | input | 1 | CSR access request |
| csr_we | input | 1 | Request is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write data |
| csr_hit | output | 1 | Address matches one of the two registers |
| csr_illegal | output | 1 | Access raises an illegal-instruction exception |
| csr_rdata | output | 64 | Read data |
| time_now | input | 64 | Free-running time value |
| ip_wmask_i | input | 64 | Software write mask for the interrupt-pending register |
| ip_wmask_o | output | 64 | Filtered write mask |
| tmr_pend_o | output | 1 | Supervisor timer pending |

## Verification
A write that moves the compare value can land in the same cycle that time_now has already reached the old value. The bench sets time equal to the current compare value, lets the pending bit rise, and then writes a later compare value. It expects the pending bit to stay high for one more cycle, because that cycle is decided by the old value, and then to fall. After that it advances time_now one step at a time across the new value with no write and checks that the bit rises on its own.

// File: rtl/suptmr_pkg.sv
package suptmr_pkg;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef enum logic {
        PEND_ARMED = 1'b0,
        PEND_DUE   = 1'b1
    } pend_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } sel_e;

endpackage

// File: rtl/suptmr_access.sv
module suptmr_access
    import suptmr_pkg::*;
#(
    parameter int          AW      = 12,
    parameter logic [11:0] ADDR_LO = 12'h14D,
    parameter logic [11:0] ADDR_HI = 12'h15D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          feat_en,
    input  logic          time_ok,
    input  logic          rv64_mode,
    input  logic [1:0]    priv_lvl,
    input  logic          cnt_time_en,
    input  logic          env_tcmp_en,
    input  logic          req,
    input  logic [AW-1:0] addr,
    output sel_e          sel,
    output logic          legal,
    output logic          illegal
);
    logic priv_ok;

    always_comb begin
        sel = SEL_NONE;
        if (req) begin
            if (addr == AW'(ADDR_LO))      sel = SEL_LO;
            else if (addr == AW'(ADDR_HI)) sel = SEL_HI;
        end
    end

    always_comb begin
        unique case (priv_e'(priv_lvl))
            PRV_MACH:  priv_ok = 1'b1;
            PRV_SUPER: priv_ok = cnt_time_en & env_tcmp_en;
            default:   priv_ok = 1'b0;
        endcase
    end

    always_comb begin
        illegal = (sel != SEL_NONE) &&
                  (!feat_en || !time_ok || !priv_ok ||
                   ((sel == SEL_HI) && rv64_mode));
        legal   = (sel != SEL_NONE) && !illegal;
    end

    // R8: user mode never reaches the register
    a_r8_user_denied: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel != SEL_NONE) && (priv_lvl == 2'd0)) |-> illegal);

    // R9: high half does not exist with 64-bit registers
    a_r9_hi_in_rv64: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_HI) && rv64_mode) |-> illegal);

    // R5: feature off or no time source
    a_r5_feature_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel != SEL_NONE) && (!feat_en || !time_ok)) |-> !legal);

endmodule

// File: rtl/suptmr_cmpreg.sv
module suptmr_cmpreg #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          rv64_mode,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] cmp_q
);
    localparam int HALF = TW / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_lo) begin
            if (rv64_mode) cmp_q <= wdata;
            else           cmp_q[HALF-1:0] <= wdata[HALF-1:0];
        end else if (wr_hi) begin
            cmp_q[TW-1:HALF] <= wdata[HALF-1:0];
        end
    end

    // R3: high-half write keeps the low half
    a_r3_hi_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (cmp_q[HALF-1:0] == $past(cmp_q[HALF-1:0])));

    // R2: 32-bit low write keeps the high half
    a_r2_lo32_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !rv64_mode) |=> (cmp_q[TW-1:HALF] == $past(cmp_q[TW-1:HALF])));

    // R7: without a legal write the value holds
    a_r7_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> $stable(cmp_q));

endmodule

// File: rtl/suptmr_pend_fsm.sv
module suptmr_pend_fsm
    import suptmr_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cmp,
    input  logic [TW-1:0] time_now,
    output logic          pend_o
);
    pend_e state_q, state_d;
    logic  due;

    assign due = (cmp <= time_now);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_ARMED: if (due)  state_d = PEND_DUE;
            PEND_DUE:   if (!due) state_d = PEND_ARMED;
            default:    state_d = PEND_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PEND_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == PEND_DUE);
    end

    // R4: pending mirrors the previous cycle's comparison
    a_r4_pend_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_o == ($past(cmp) <= $past(time_now))));

endmodule

// File: rtl/suptmr_cmp_unit.sv
module suptmr_cmp_unit
    import suptmr_pkg::*;
#(
    parameter int          TW        = 64,
    parameter int          AW        = 12,
    parameter int          IPW       = 64,
    parameter int          STIP_BIT  = 5,
    parameter int          VSTIP_BIT = 6,
    parameter logic [11:0] ADDR_LO   = 12'h14D,
    parameter logic [11:0] ADDR_HI   = 12'h15D
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           feat_en,
    input  logic           time_ok,
    input  logic           rv64_mode,
    input  logic [1:0]     priv_lvl,
    input  logic           cnt_time_en,
    input  logic           env_tcmp_en,
    input  logic           csr_req,
    input  logic           csr_we,
    input  logic [AW-1:0]  csr_addr,
    input  logic [TW-1:0]  csr_wdata,
    output logic           csr_hit,
    output logic           csr_illegal,
    output logic [TW-1:0]  csr_rdata,
    input  logic [TW-1:0]  time_now,
    input  logic [IPW-1:0] ip_wmask_i,
    output logic [IPW-1:0] ip_wmask_o,
    output logic           tmr_pend_o
);
    localparam int HALF = TW / 2;
    localparam logic [IPW-1:0] LOCK_BITS =
        (IPW'(1) << STIP_BIT) | (IPW'(1) << VSTIP_BIT);

    sel_e          sel;
    logic          legal;
    logic          wr_lo, wr_hi;
    logic [TW-1:0] cmp_q;
    logic          ip_lock;

    suptmr_access #(.AW(AW), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_access (
        .clk         (clk),
        .rst_n       (rst_n),
        .feat_en     (feat_en),
        .time_ok     (time_ok),
        .rv64_mode   (rv64_mode),
        .priv_lvl    (priv_lvl),
        .cnt_time_en (cnt_time_en),
        .env_tcmp_en (env_tcmp_en),
        .req         (csr_req),
        .addr        (csr_addr),
        .sel         (sel),
        .legal       (legal),
        .illegal     (csr_illegal)
    );

    assign csr_hit = (sel != SEL_NONE);
    assign wr_lo   = legal && csr_we && (sel == SEL_LO);
    assign wr_hi   = legal && csr_we && (sel == SEL_HI);

    suptmr_cmpreg #(.TW(TW)) u_cmpreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .rv64_mode (rv64_mode),
        .wdata     (csr_wdata),
        .cmp_q     (cmp_q)
    );

    suptmr_pend_fsm #(.TW(TW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp      (cmp_q),
        .time_now (time_now),
        .pend_o   (tmr_pend_o)
    );

    always_comb begin
        csr_rdata = '0;
        if (legal) begin
            unique case (sel)
                SEL_LO:  csr_rdata = rv64_mode ? cmp_q
                                               : {{HALF{1'b0}}, cmp_q[HALF-1:0]};
                SEL_HI:  csr_rdata = {{HALF{1'b0}}, cmp_q[TW-1:HALF]};
                default: csr_rdata = '0;
            endcase
        end
    end

    assign ip_lock    = feat_en && (priv_lvl == 2'd3) && env_tcmp_en;
    assign ip_wmask_o = ip_lock ? (ip_wmask_i & ~LOCK_BITS) : ip_wmask_i;

    // R10: locked pending bits never pass
    a_r10_bits_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ip_lock |-> (!ip_wmask_o[STIP_BIT] && !ip_wmask_o[VSTIP_BIT]));

    // R10: other bits always pass
    a_r10_others_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ((ip_wmask_o | LOCK_BITS) == (ip_wmask_i | LOCK_BITS)));

    // R11: illegal access returns zero
    a_r11_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0));

endmodule

// File: tb/suptmr_cmp_unit_tb_top.sv
module suptmr_cmp_unit_tb_top;

    typedef struct packed {
        logic [1:0]  pv;
        logic        r64;
        logic        cn;
        logic        en;
        logic        hi;
        logic [63:0] wd;
        logic [63:0] tm;
        logic        ill;
        logic [63:0] ex;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [0:NV-1] = '{
        '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0000_0010_0000_0100, 64'h50,
          1'b0, 64'h0000_0010_0000_0100, 4'd2},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0020, 64'h0000_0010_0000_0020,
          1'b0, 64'h0000_0010_0000_0020, 4'd2},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 64'hDEAD_BEEF_0000_0000, 64'h1F,
          1'b0, 64'h0000_0000_0000_0020, 4'd3},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF,
          1'b0, 64'h1234_5678_9ABC_DEF0, 4'd7},
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 64'h55, 64'h0,
          1'b1, 64'h1234_5678_9ABC_DEF0, 4'd7},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h66, 64'h1234_5678_9ABC_DEF0,
          1'b1, 64'h1234_5678_9ABC_DEF0, 4'd7},
        '{2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h77, 64'h0,
          1'b1, 64'h1234_5678_9ABC_DEF0, 4'd8},
        '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1, 64'h0,
          1'b1, 64'h1234_5678_9ABC_DEF0, 4'd9},
        '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0000_0000_AAAA_BBBB, 64'hAAAA_BBBB_9ABC_DEF1,
          1'b0, 64'hAAAA_BBBB_9ABC_DEF0, 4'd3}
    };

    localparam logic [11:0] A_LO = 12'h14D;
    localparam logic [11:0] A_HI = 12'h15D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_en = 1'b1, time_ok = 1'b1, rv64_mode = 1'b1;
    logic [1:0]  priv_lvl = 2'd3;
    logic        cnt_time_en = 1'b0, env_tcmp_en = 1'b0;
    logic        csr_req = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = 12'h0;
    logic [63:0] csr_wdata = '0;
    logic        csr_hit, csr_illegal, tmr_pend_o;
    logic [63:0] csr_rdata;
    logic [63:0] time_now = '0;
    logic [63:0] ip_wmask_i = '0;
    logic [63:0] ip_wmask_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    suptmr_cmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .time_ok(time_ok),
        .rv64_mode(rv64_mode), .priv_lvl(priv_lvl), .cnt_time_en(cnt_time_en),
        .env_tcmp_en(env_tcmp_en), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_hit(csr_hit),
        .csr_illegal(csr_illegal), .csr_rdata(csr_rdata), .time_now(time_now),
        .ip_wmask_i(ip_wmask_i), .ip_wmask_o(ip_wmask_o), .tmr_pend_o(tmr_pend_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] pv, input logic r64, input logic cn,
                         input logic en, input logic we, input logic [11:0] a,
                         input logic [63:0] wd);
        priv_lvl = pv; rv64_mode = r64; cnt_time_en = cn; env_tcmp_en = en;
        csr_req = 1'b1; csr_we = we; csr_addr = a; csr_wdata = wd;
    endtask

    task automatic idle();
        csr_req = 1'b0; csr_we = 1'b0;
    endtask

    task automatic readback(output logic [63:0] v);
        drive(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, A_LO, '0);
        #1 v = csr_rdata;
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] rb;
        // R1: reset state
        repeat (3) @(negedge clk);
        readback(rb);
        check("R1 reset compare", rb, 64'h0);
        check("R1 reset pending", {63'b0, tmr_pend_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 zero compare due", {63'b0, tmr_pend_o}, 64'h1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i].pv, VT[i].r64, VT[i].cn, VT[i].en, 1'b1,
                  VT[i].hi ? A_HI : A_LO, VT[i].wd);
            #1;
            check($sformatf("R%0d illegal v%0d", VT[i].rq, i), {63'b0, csr_illegal}, {63'b0, VT[i].ill});
            @(negedge clk);
            idle();
            time_now = VT[i].tm;
            readback(rb);
            check($sformatf("R%0d value v%0d", VT[i].rq, i), rb, VT[i].ex);
            @(negedge clk); #1;
            check($sformatf("R4 pending v%0d", i), {63'b0, tmr_pend_o},
                  {63'b0, (VT[i].ex <= VT[i].tm)});
        end

        // R11: read widths (compare = AAAABBBB_9ABCDEF0)
        @(negedge clk);
        drive(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, A_LO, '0); #1;
        check("R11 rv32 low read", csr_rdata, 64'h0000_0000_9ABC_DEF0);
        drive(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, A_HI, '0); #1;
        check("R3 high read", csr_rdata, 64'h0000_0000_AAAA_BBBB);
        drive(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, A_LO, '0); #1;
        check("R11 illegal read zero", csr_rdata, 64'h0);
        drive(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 12'h140, '0); #1;
        check("R11 other address", {62'b0, csr_hit, csr_illegal}, 64'h0);
        idle();

        // R5: feature off / no time source
        @(negedge clk);
        feat_en = 1'b0;
        drive(2'd3, 1'b1, 1'b1, 1'b1, 1'b1, A_LO, 64'h77); #1;
        check("R5 feature off illegal", {63'b0, csr_illegal}, 64'h1);
        @(negedge clk);
        feat_en = 1'b1; time_ok = 1'b0;
        drive(2'd3, 1'b1, 1'b1, 1'b1, 1'b1, A_LO, 64'h78); #1;
        check("R5 no time illegal", {63'b0, csr_illegal}, 64'h1);
        @(negedge clk);
        idle(); time_ok = 1'b1;
        readback(rb);
        check("R5 value unchanged", rb, 64'hAAAA_BBBB_9ABC_DEF0);

        // R6: machine mode with both enables clear
        @(negedge clk);
        time_now = 64'h100;
        drive(2'd3, 1'b1, 1'b0, 1'b0, 1'b1, A_LO, 64'h100); #1;
        check("R6 machine legal", {63'b0, csr_illegal}, 64'h0);
        @(negedge clk);
        idle();
        readback(rb);
        check("R6 machine write", rb, 64'h100);
        @(negedge clk); #1;
        check("R4 equal is due", {63'b0, tmr_pend_o}, 64'h1);

        // R4: write a later value while due
        drive(2'd3, 1'b1, 1'b0, 1'b0, 1'b1, A_LO, 64'h200);
        @(negedge clk); #1;
        idle();
        check("R4 old value cycle", {63'b0, tmr_pend_o}, 64'h1);
        @(negedge clk); #1;
        check("R4 new value cycle", {63'b0, tmr_pend_o}, 64'h0);
        time_now = 64'h1FF;
        @(negedge clk); #1;
        check("R4 one before", {63'b0, tmr_pend_o}, 64'h0);
        time_now = 64'h200;
        @(negedge clk); #1;
        check("R4 time reaches", {63'b0, tmr_pend_o}, 64'h1);

        // R10: pending-write mask
        ip_wmask_i = '1;
        priv_lvl = 2'd3; env_tcmp_en = 1'b1; feat_en = 1'b1; #1;
        check("R10 locked", ip_wmask_o, ~64'h60);
        priv_lvl = 2'd1; #1;
        check("R10 supervisor pass", ip_wmask_o, '1);
        priv_lvl = 2'd3; env_tcmp_en = 1'b0; #1;
        check("R10 enable clear pass", ip_wmask_o, '1);
        env_tcmp_en = 1'b1; feat_en = 1'b0; #1;
        check("R10 feature off pass", ip_wmask_o, '1);
        feat_en = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule